// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block keeps the program counter of a small processor whose instructions are 14 bits wide, and it picks the program-memory address for each cycle. Each cycle it reads the instruction word at the current address. It also reads a skip-condition bit from the execute unit, which says whether a test instruction found its condition true. From these two inputs it chooses the next address. That address is one of four things: the next sequential address, a jump target, a subroutine entry, or an address taken back off the internal return stack.

Conditional flow never names a target. A test instruction whose condition holds cancels the one instruction after it. That instruction is still fetched and still uses its cycle, but the squash output is high for that slot, so the execute unit performs no writes. The squashed word also has no effect on sequencing. Subroutine linkage uses a dedicated eight-entry stack that holds 11-bit addresses. Two sticky flags report when the stack is pushed while full or popped while empty.

Top module: `programSequencer`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, the fetch address is 0, squash is low, both stack flags are low and the stack is empty. Reset is active-low.
- R2: For any instruction that is not a jump, call or return, the next fetch address is the current address plus one, modulo 2048. Address 0x7FF is followed by 0.
- R3: A jump is any word whose bits 13:11 are 101. It loads bits 10:0 into the program counter. For example, 0x2806 leads to address 6.
- R4: A call is any word whose bits 13:11 are 100. It pushes the current address plus one onto the stack and loads bits 10:0 into the program counter.
- R5: A return is the word 0x0008. It pops the most recently pushed address from the stack into the program counter.
- R6: Four kinds of instruction are test instructions. Their top bits are 001011 (decrement-and-skip), 001111 (increment-and-skip), 0110 (skip if bit clear) and 0111 (skip if bit set). When a test instruction that is not itself squashed sees the skip-condition input high, squash is high in the next slot. For any other instruction, the skip-condition input has no effect.
- R7: In a squashed slot, the instruction word is ignored. It causes no jump, no push, no pop and no further squash, and the address advances by one.
- R8: A push onto a stack that already holds 8 entries sets the overflow flag and overwrites the oldest entry. The flag stays set until reset.
- R9: A pop from an empty stack sets the underflow flag and loads address 0. The stack is left unchanged, and the flag stays set until reset.
- R10: The stack holds 8 addresses. After eight pushes, eight pops return those addresses in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrWord | input | 14 | Instruction fetched from the current address |
| skipCond | input | 1 | Execute unit reports that the current test condition is true |
| fetchAddr | output | 11 | Program-memory address for the current slot |
| squash | output | 1 | Current slot is cancelled; the execute unit must not write |
| stackOverflow | output | 1 | Sticky: a push happened while the stack was full |
| stackUnderflow | output | 1 | Sticky: a pop happened while the stack was empty |

## Verification
A fault in the program counter or in the squash register shows on the fetch address or on the squash output one cycle after the instruction that caused it. An error in the stack pointer or the entry count stays hidden until a return executes. It then shows as a wrong return address, or as a flag that rises at the wrong moment. The stack test therefore fills the stack past its depth and drains it completely, so that every slot and the wrap of the pointer are observed.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int INSTR_W = 14;

  localparam logic [2:0] OP_CALL = 3'b100;
  localparam logic [2:0] OP_GOTO = 3'b101;
  localparam logic [INSTR_W-1:0] WORD_RETURN = 14'h0008;

  // top-bit patterns of the four test instructions
  localparam logic [5:0] OP_DEC_SKIP = 6'b001011;
  localparam logic [5:0] OP_INC_SKIP = 6'b001111;
  localparam logic [3:0] OP_BIT_CLR  = 4'b0110;
  localparam logic [3:0] OP_BIT_SET  = 4'b0111;

  typedef struct packed {
    logic pushRet;
    logic popRet;
    logic loadTarget;
  } seqStrobeT;

  function automatic logic isTestInstr(input logic [INSTR_W-1:0] w);
    return (w[13:8] == OP_DEC_SKIP) || (w[13:8] == OP_INC_SKIP) ||
           (w[13:10] == OP_BIT_CLR) || (w[13:10] == OP_BIT_SET);
  endfunction
endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               skipCond,
  output seqStrobeT          strobe,
  output logic               squash
);
  logic squashQ;
  logic active;
  logic isCall;
  logic isGoto;
  logic isReturn;
  logic isTest;

  always_comb begin
    active   = !squashQ;
    isCall   = instrWord[13:11] == OP_CALL;
    isGoto   = instrWord[13:11] == OP_GOTO;
    isReturn = instrWord == WORD_RETURN;
    isTest   = isTestInstr(instrWord);

    strobe.pushRet    = active && isCall;
    strobe.popRet     = active && isReturn;
    strobe.loadTarget = active && (isCall || isGoto);
  end

  always_ff @(posedge clk) begin
    if (!rstN) squashQ <= 1'b0;
    else       squashQ <= active && isTest && skipCond;
  end

  assign squash = squashQ;
endmodule

// File: rtl/returnStack.sv
module returnStack #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushData,
  output logic [ADDR_W-1:0] popData,
  output logic              overflow,
  output logic              underflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  topPtr;
  logic [CNT_W-1:0]  count;
  logic              isEmpty;
  logic              isFull;

  always_comb begin
    isEmpty = count == '0;
    isFull  = count == FULL_CNT;
    topPtr  = (wrPtr == '0) ? LAST_PTR : wrPtr - PTR_W'(1);
    popData = isEmpty ? '0 : slot[topPtr];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                              slot[i] <= '0;
      else if (push && wrPtr == PTR_W'(i))    slot[i] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (push) begin
      wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (isFull) overflow <= 1'b1;
      else        count    <= count + CNT_W'(1);
    end else if (pop) begin
      if (isEmpty) begin
        underflow <= 1'b1;
      end else begin
        wrPtr <= topPtr;
        count <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] popData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] retAddr
);
  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    retAddr = pcQ + ADDR_W'(1);
    if (strobe.loadTarget)  pcNext = target;
    else if (strobe.popRet) pcNext = popData;
    else                    pcNext = retAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

  assign pc = pcQ;
endmodule

// File: rtl/programSequencer.sv
module programSequencer
  import seqPkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int STACK_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               skipCond,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic               squash,
  output logic               stackOverflow,
  output logic               stackUnderflow
);
  seqStrobeT         strobe;
  logic [ADDR_W-1:0] retAddr;
  logic [ADDR_W-1:0] popData;

  seqControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .skipCond  (skipCond),
    .strobe    (strobe),
    .squash    (squash)
  );

  seqDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .target  (instrWord[ADDR_W-1:0]),
    .popData (popData),
    .pc      (fetchAddr),
    .retAddr (retAddr)
  );

  returnStack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rstN      (rstN),
    .push      (strobe.pushRet),
    .pop       (strobe.popRet),
    .pushData  (retAddr),
    .popData   (popData),
    .overflow  (stackOverflow),
    .underflow (stackUnderflow)
  );
endmodule

// File: rtl/seqChecker.sv
module seqChecker
  import seqPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic [INSTR_W-1:0] instrWord,
  input logic               skipCond,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic               squash,
  input logic               stackOverflow,
  input logic               stackUnderflow
);
  logic plainWord;
  assign plainWord = (instrWord[13:11] != OP_CALL) && (instrWord[13:11] != OP_GOTO) &&
                     (instrWord != WORD_RETURN);

  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (fetchAddr == '0) && !squash && !stackOverflow && !stackUnderflow);

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!squash && plainWord) |=> fetchAddr == ADDR_W'($past(fetchAddr) + ADDR_W'(1)));

  p_goto_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!squash && instrWord[13:11] == OP_GOTO) |=> fetchAddr == $past(instrWord[ADDR_W-1:0]));

  p_call_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!squash && instrWord[13:11] == OP_CALL) |=> fetchAddr == $past(instrWord[ADDR_W-1:0]));

  p_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!squash && skipCond && isTestInstr(instrWord)) |=> squash);

  p_no_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!isTestInstr(instrWord) || !skipCond) |=> !squash);

  p_squash_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    squash |=> (fetchAddr == ADDR_W'($past(fetchAddr) + ADDR_W'(1))) && !squash);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    stackOverflow |=> stackOverflow);

  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackUnderflow |=> stackUnderflow);

  p_unf_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stackUnderflow) |-> fetchAddr == '0);
endmodule

bind programSequencer seqChecker #(.ADDR_W(ADDR_W)) i_seqChecker (
  .clk            (clk),
  .rstN           (rstN),
  .instrWord      (instrWord),
  .skipCond       (skipCond),
  .fetchAddr      (fetchAddr),
  .squash         (squash),
  .stackOverflow  (stackOverflow),
  .stackUnderflow (stackUnderflow)
);

// File: tb/test_programSequencer.sv
module test_programSequencer;
  localparam int AW = 11;
  localparam logic [13:0] NOP = 14'h0000;
  localparam logic [13:0] RET = 14'h0008;
  localparam logic [13:0] DEC_SKIP = 14'h0BA0;
  localparam logic [13:0] INC_SKIP = 14'h0FA0;
  localparam logic [13:0] BIT_CLR  = 14'h1820;
  localparam logic [13:0] BIT_SET  = 14'h1C20;

  typedef struct {
    logic [AW-1:0] addr;
    logic          sq;
    logic          ovf;
    logic          unf;
    string         tag;
  } expItemT;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [13:0]   instrWord;
  logic          skipCond;
  logic [AW-1:0] fetchAddr;
  logic          squash;
  logic          stackOverflow;
  logic          stackUnderflow;

  logic [13:0]   prog [2048];
  logic          cond [2048];
  expItemT       expQ [$];
  int            checks = 0;
  int            errors = 0;
  logic          finished = 1'b0;

  always #4 clk = ~clk;

  assign instrWord = prog[fetchAddr];
  assign skipCond  = cond[fetchAddr];

  programSequencer i_programSequencer (
    .clk            (clk),
    .rstN           (rstN),
    .instrWord      (instrWord),
    .skipCond       (skipCond),
    .fetchAddr      (fetchAddr),
    .squash         (squash),
    .stackOverflow  (stackOverflow),
    .stackUnderflow (stackUnderflow)
  );

  function automatic logic [13:0] goto_w(input int a);
    return 14'h2800 | 14'(a);
  endfunction

  function automatic logic [13:0] call_w(input int a);
    return 14'h2000 | 14'(a);
  endfunction

  task automatic expect_slot(input int a, input logic s, input logic o, input logic u,
                             input string tag);
    expItemT it;
    it.addr = AW'(a);
    it.sq   = s;
    it.ovf  = o;
    it.unf  = u;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 2048; i++) begin
      prog[i] = NOP;
      cond[i] = 1'b0;
    end
  endtask

  // hold reset, check the reset state, then release and let the monitor drain the queue
  task automatic run_scenario();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (fetchAddr != '0 || squash || stackOverflow || stackUnderflow) begin
      errors++;
      $display("FAIL R1 reset state: addr=%0h sq=%0b ovf=%0b unf=%0b expected 0 0 0 0",
               fetchAddr, squash, stackOverflow, stackUnderflow);
    end
    @(posedge clk);
    #1 rstN = 1'b1;
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: pops one expected slot per cycle and compares it with the ports
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      expItemT it;
      it = expQ.pop_front();
      checks++;
      if (fetchAddr !== it.addr || squash !== it.sq ||
          stackOverflow !== it.ovf || stackUnderflow !== it.unf) begin
        errors++;
        $display("FAIL %s: addr=%0h sq=%0b ovf=%0b unf=%0b expected addr=%0h sq=%0b ovf=%0b unf=%0b",
                 it.tag, fetchAddr, squash, stackOverflow, stackUnderflow,
                 it.addr, it.sq, it.ovf, it.unf);
      end
    end
  end

  initial begin
    // scenario A: sequential advance, jumps, wrap at the top of the address space (R2, R3)
    clear_prog();
    prog[3]  = goto_w(6);
    prog[8]  = goto_w(11'h7FE);
    cond[1]  = 1'b1;
    expect_slot(0, 0, 0, 0, "R1");
    expect_slot(1, 0, 0, 0, "R2");
    expect_slot(2, 0, 0, 0, "R2 skipCond on plain word");
    expect_slot(3, 0, 0, 0, "R2");
    expect_slot(6, 0, 0, 0, "R3 jump to 6");
    expect_slot(7, 0, 0, 0, "R2");
    expect_slot(8, 0, 0, 0, "R2");
    expect_slot(11'h7FE, 0, 0, 0, "R3 jump high");
    expect_slot(11'h7FF, 0, 0, 0, "R2");
    expect_slot(0, 0, 0, 0, "R2 wrap");
    expect_slot(1, 0, 0, 0, "R2");
    run_scenario();

    // scenario B: call and return loop (R3, R4, R5)
    clear_prog();
    prog[0] = goto_w(5);
    prog[5] = call_w(7);
    prog[6] = goto_w(5);
    prog[7] = 14'h0AA2;
    prog[8] = RET;
    expect_slot(0, 0, 0, 0, "R1");
    for (int k = 0; k < 3; k++) begin
      expect_slot(5, 0, 0, 0, "R3");
      expect_slot(7, 0, 0, 0, "R4 call target");
      expect_slot(8, 0, 0, 0, "R2");
      expect_slot(6, 0, 0, 0, "R5 return address");
    end
    run_scenario();

    // scenario C: skips, squashed slots, empty-stack return (R6, R7, R9, R1 stack cleared)
    clear_prog();
    prog[0] = DEC_SKIP; cond[0] = 1'b1;
    prog[1] = goto_w(11'h10);
    prog[2] = BIT_CLR;
    prog[3] = NOP;      cond[3] = 1'b1;
    prog[4] = BIT_SET;  cond[4] = 1'b1;
    prog[5] = INC_SKIP; cond[5] = 1'b1;
    prog[6] = BIT_CLR;  cond[6] = 1'b1;
    prog[7] = call_w(11'h20);
    prog[8] = RET;
    expect_slot(0, 0, 0, 0, "R1");
    expect_slot(1, 1, 0, 0, "R6 decrement skip");
    expect_slot(2, 0, 0, 0, "R7 squashed jump ignored");
    expect_slot(3, 0, 0, 0, "R6 condition false");
    expect_slot(4, 0, 0, 0, "R6 plain word not test");
    expect_slot(5, 1, 0, 0, "R6 bit-set skip");
    expect_slot(6, 0, 0, 0, "R7 squashed test ignored");
    expect_slot(7, 1, 0, 0, "R6 bit-clear skip");
    expect_slot(8, 0, 0, 0, "R7 squashed call ignored");
    expect_slot(0, 0, 0, 1, "R9 empty pop");
    expect_slot(1, 1, 0, 1, "R9 sticky");
    run_scenario();

    // scenario D: nine nested calls then unwind to an empty pop (R8, R10, R9)
    clear_prog();
    for (int k = 0; k < 9; k++) begin
      prog[2*k]   = call_w(2*k + 2);
      prog[2*k+1] = RET;
    end
    prog[18] = RET;
    for (int k = 0; k < 9; k++) expect_slot(2*k, 0, 0, 0, "R4 nested call");
    expect_slot(18, 0, 1, 0, "R8 overflow on ninth push");
    for (int k = 8; k >= 1; k--) expect_slot(2*k + 1, 0, 1, 0, "R10 LIFO order");
    expect_slot(0, 0, 1, 1, "R9 oldest entry overwritten, then empty");
    expect_slot(2, 0, 1, 1, "R8 sticky");
    run_scenario();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule